// File: doc/BRIEF.md
# Byte ALU with Condition Flags

This block is the arithmetic and logic unit of a small accumulator-style processor. Each cycle in which `in_valid` is high it takes a register operand `opa`, a second operand `opm`, the incoming carry and a four-bit operation code. One clock later it presents the result, the four condition flags (negative, overflow, zero, carry) and a separate update enable for each flag. The enclosing core writes a flag into its status register only when that flag's enable is high. Decimal arithmetic is not supported, and the register file and memory paths belong to the core.

A single adder serves addition, subtraction, increment, decrement and compare. Subtraction adds the inverse of `opm` to the incoming carry, so a carry of one means no borrow. Compare and bit-test have their own flag rules. Compare leaves overflow alone. Bit-test takes its negative and overflow flags straight from the top two bits of `opm`.

Top module: `byte_alu`

## Requirements
- R1: Outputs are registered. An operation presented with `in_valid` high appears on `result`, the flags and the enables after the next rising clock edge, with `out_valid` high. While `in_valid` is low, `out_valid` reads 0 and `result`, the flags and the enables keep their last values.
- R2: Add (code 0): `{flag_c, result}` equals `opa + opm + carry_in` taken as a 9-bit sum. All four flag enables are high.
- R3: For add and subtract, `flag_v` is bit 7 of `(B xor R) and (R xor opa)`, where R is `result` and B is `opm` for add or `~opm` for subtract. This equals signed overflow.
- R4: Subtract (code 1): `result` equals `opa + ~opm + carry_in` modulo 256. `flag_c` is the carry out, so it is 1 when no borrow occurred. All four enables are high.
- R5: AND (code 2), XOR (code 3) and OR (code 4) combine `opa` and `opm` bitwise. Only the N and Z enables are high.
- R6: Shift left (code 5) moves `opa[7]` into C and fills bit 0 with zero. Shift right (code 6) moves `opa[0]` into C and fills bit 7 with zero whatever `carry_in` is. The N, Z and C enables are high.
- R7: Rotate left (code 7) puts `carry_in` into bit 0 and rotate right (code 8) puts it into bit 7. The bit shifted out becomes C. The N, Z and C enables are high.
- R8: Increment (code 9) and decrement (code 10) act on `opa` and wrap modulo 256. Only the N and Z enables are high, so carry and overflow are left unchanged.
- R9: Compare (code 11): `result` is `opa - opm` modulo 256. `flag_c` is 1 when `opm <= opa`. N and Z come from `result`. `upd_v` is 0.
- R10: Bit-test (code 12): `result` is `opa & opm`, and `flag_z` is 1 when that is zero. `flag_n` is `opm[7]` and `flag_v` is `opm[6]`. `upd_c` is 0.
- R11: Codes 13 to 15 pass `opa` to `result` with every enable low. A flag whose enable is low always reads 0.
- R12: After reset, every output reads 0.
- R13: For every operation except bit-test, an enabled `flag_z` is 1 exactly when `result` is zero, and an enabled `flag_n` equals `result[7]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 4 | Operation code |
| opa | input | WIDTH | Register operand |
| opm | input | WIDTH | Second operand |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result registered from a valid operation |
| result | output | WIDTH | Operation result |
| flag_n | output | 1 | Negative flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| upd_n | output | 1 | Write enable for N |
| upd_v | output | 1 | Write enable for V |
| upd_z | output | 1 | Write enable for Z |
| upd_c | output | 1 | Write enable for C |

## Verification
The bench builds the block with the default `WIDTH` of 8, so every boundary can be written as a byte literal: sign-bit crossings (0x7F to 0x80), wrap at 0xFF/0x00, the equal-operand compare, and the bit-6/bit-7 sources of the bit-test flags. It also runs a grid of additions over both carry-in values. The expected signed overflow for that grid is derived from integer range checks rather than from the XOR rule, so the two formulations cross-check each other.

// File: rtl/byte_alu_pkg.sv
`timescale 1ns/1ps
package byte_alu_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_AND = 4'd2,
        OP_XOR = 4'd3,
        OP_OR  = 4'd4,
        OP_SHL = 4'd5,
        OP_SHR = 4'd6,
        OP_ROL = 4'd7,
        OP_ROR = 4'd8,
        OP_INC = 4'd9,
        OP_DEC = 4'd10,
        OP_CMP = 4'd11,
        OP_BIT = 4'd12
    } alu_op_e;

    typedef enum logic [1:0] {
        SH_LEFT  = 2'd0,
        SH_RIGHT = 2'd1,
        SH_ROTL  = 2'd2,
        SH_ROTR  = 2'd3
    } shift_mode_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_XOR = 2'd1,
        LG_OR  = 2'd2
    } logic_sel_e;

endpackage

// File: rtl/byte_alu_adder.sv
`timescale 1ns/1ps
module byte_alu_adder #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout,
    output logic             ovf
);
    localparam int MSB = WIDTH - 1;

    logic [WIDTH:0] full;

    always_comb begin
        full = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
        sum  = full[MSB:0];
        cout = full[WIDTH];
        // signed overflow: result sign disagrees with both operand signs
        ovf  = (b[MSB] ^ full[MSB]) & (full[MSB] ^ a[MSB]);
    end
endmodule

// File: rtl/byte_alu_shifter.sv
`timescale 1ns/1ps
module byte_alu_shifter
    import byte_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic             cin,
    input  shift_mode_e      mode,
    output logic [WIDTH-1:0] res,
    output logic             cout
);
    localparam int MSB = WIDTH - 1;

    always_comb begin
        case (mode)
            SH_LEFT: begin
                res  = {a[MSB-1:0], 1'b0};
                cout = a[MSB];
            end
            SH_RIGHT: begin
                res  = {1'b0, a[MSB:1]};
                cout = a[0];
            end
            SH_ROTL: begin
                res  = {a[MSB-1:0], cin};
                cout = a[MSB];
            end
            default: begin
                res  = {cin, a[MSB:1]};
                cout = a[0];
            end
        endcase
    end
endmodule

// File: rtl/byte_alu_logic.sv
`timescale 1ns/1ps
module byte_alu_logic
    import byte_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] m,
    input  logic_sel_e       sel,
    output logic [WIDTH-1:0] res
);
    always_comb begin
        case (sel)
            LG_XOR:  res = a ^ m;
            LG_OR:   res = a | m;
            default: res = a & m;
        endcase
    end
endmodule

// File: rtl/byte_alu.sv
`timescale 1ns/1ps
module byte_alu
    import byte_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [3:0]       op,
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opm,
    input  logic             carry_in,
    output logic             out_valid,
    output logic [WIDTH-1:0] result,
    output logic             flag_n,
    output logic             flag_v,
    output logic             flag_z,
    output logic             flag_c,
    output logic             upd_n,
    output logic             upd_v,
    output logic             upd_z,
    output logic             upd_c
);
    localparam int MSB  = WIDTH - 1;
    localparam int VBIT = WIDTH - 2;

    typedef struct packed {
        logic             vld;
        logic [WIDTH-1:0] res;
        logic             n;
        logic             v;
        logic             z;
        logic             c;
        logic             en_n;
        logic             en_v;
        logic             en_z;
        logic             en_c;
    } alu_state_t;

    alu_state_t st_d, st_q;

    alu_op_e          op_e;
    logic [WIDTH-1:0] add_b;
    logic             add_cin;
    logic [WIDTH-1:0] add_sum;
    logic             add_cout;
    logic             add_ovf;
    shift_mode_e      sh_mode;
    logic [WIDTH-1:0] sh_res;
    logic             sh_cout;
    logic_sel_e       lg_sel;
    logic [WIDTH-1:0] lg_res;

    assign op_e = alu_op_e'(op);

    // operand steering for the shared adder
    always_comb begin
        add_b   = opm;
        add_cin = carry_in;
        case (op_e)
            OP_SUB: add_b = ~opm;
            OP_CMP: begin
                add_b   = ~opm;
                add_cin = 1'b1;
            end
            OP_INC: begin
                add_b   = '0;
                add_cin = 1'b1;
            end
            OP_DEC: begin
                add_b   = '1;
                add_cin = 1'b0;
            end
            default: ;
        endcase
    end

    always_comb begin
        case (op_e)
            OP_SHR:  sh_mode = SH_RIGHT;
            OP_ROL:  sh_mode = SH_ROTL;
            OP_ROR:  sh_mode = SH_ROTR;
            default: sh_mode = SH_LEFT;
        endcase
    end

    always_comb begin
        case (op_e)
            OP_XOR:  lg_sel = LG_XOR;
            OP_OR:   lg_sel = LG_OR;
            default: lg_sel = LG_AND;
        endcase
    end

    byte_alu_adder #(.WIDTH(WIDTH)) u_adder (
        .a    (opa),
        .b    (add_b),
        .cin  (add_cin),
        .sum  (add_sum),
        .cout (add_cout),
        .ovf  (add_ovf)
    );

    byte_alu_shifter #(.WIDTH(WIDTH)) u_shift (
        .a    (opa),
        .cin  (carry_in),
        .mode (sh_mode),
        .res  (sh_res),
        .cout (sh_cout)
    );

    byte_alu_logic #(.WIDTH(WIDTH)) u_logic (
        .a   (opa),
        .m   (opm),
        .sel (lg_sel),
        .res (lg_res)
    );

    // next-state computation
    always_comb begin
        logic             raw_n, raw_v, raw_c;
        logic [WIDTH-1:0] r;

        st_d     = st_q;
        st_d.vld = in_valid;
        r        = opa;
        raw_n    = 1'b0;
        raw_v    = 1'b0;
        raw_c    = 1'b0;

        if (in_valid) begin
            st_d.en_n = 1'b0;
            st_d.en_v = 1'b0;
            st_d.en_z = 1'b0;
            st_d.en_c = 1'b0;
            case (op_e)
                OP_ADD, OP_SUB: begin
                    r     = add_sum;
                    raw_c = add_cout;
                    raw_v = add_ovf;
                    {st_d.en_n, st_d.en_v, st_d.en_z, st_d.en_c} = 4'b1111;
                end
                OP_AND, OP_XOR, OP_OR: begin
                    r = lg_res;
                    {st_d.en_n, st_d.en_z} = 2'b11;
                end
                OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                    r     = sh_res;
                    raw_c = sh_cout;
                    {st_d.en_n, st_d.en_z, st_d.en_c} = 3'b111;
                end
                OP_INC, OP_DEC: begin
                    r = add_sum;
                    {st_d.en_n, st_d.en_z} = 2'b11;
                end
                OP_CMP: begin
                    r     = add_sum;
                    raw_c = add_cout;
                    {st_d.en_n, st_d.en_z, st_d.en_c} = 3'b111;
                end
                OP_BIT: begin
                    r = lg_res;
                    {st_d.en_n, st_d.en_v, st_d.en_z} = 3'b111;
                end
                default: r = opa;
            endcase

            raw_n = (op_e == OP_BIT) ? opm[MSB] : r[MSB];
            if (op_e == OP_BIT) begin
                raw_v = opm[VBIT];
            end

            st_d.res = r;
            st_d.n   = raw_n & st_d.en_n;
            st_d.v   = raw_v & st_d.en_v;
            st_d.z   = (r == '0) & st_d.en_z;
            st_d.c   = raw_c & st_d.en_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign result    = st_q.res;
    assign flag_n    = st_q.n;
    assign flag_v    = st_q.v;
    assign flag_z    = st_q.z;
    assign flag_c    = st_q.c;
    assign upd_n     = st_q.en_n;
    assign upd_v     = st_q.en_v;
    assign upd_z     = st_q.en_z;
    assign upd_c     = st_q.en_c;

endmodule

// File: rtl/byte_alu_chk.sv
`timescale 1ns/1ps
module byte_alu_chk
    import byte_alu_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [3:0]       op,
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opm,
    input logic             carry_in,
    input logic             out_valid,
    input logic [WIDTH-1:0] result,
    input logic             flag_n,
    input logic             flag_v,
    input logic             flag_z,
    input logic             flag_c,
    input logic             upd_n,
    input logic             upd_v,
    input logic             upd_z,
    input logic             upd_c
);
    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R1
    hold_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(result) && $stable(flag_c)));

    // R2
    add_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_ADD) |=>
        ({flag_c, result} == ({1'b0, $past(opa)} + {1'b0, $past(opm)}
                              + {{WIDTH{1'b0}}, $past(carry_in)})));

    // R8
    incdec_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op == OP_INC || op == OP_DEC)) |=> (!upd_c && !upd_v));

    // R9
    cmp_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_CMP) |=>
        (!upd_v && upd_c && flag_c == ($past(opm) <= $past(opa))));

    // R10
    bit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op == OP_BIT) |=>
        (!upd_c && flag_n == $past(opm[WIDTH-1]) && flag_v == $past(opm[WIDTH-2])));

    // R11
    masked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd_n -> !flag_n) && (!upd_v -> !flag_v) &&
        (!upd_z -> !flag_z) && (!upd_c -> !flag_c));

    // R13
    zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (!upd_z || flag_z == (result == '0)));

    // R13
    neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op != OP_BIT) |=> (!upd_n || flag_n == result[WIDTH-1]));

endmodule

bind byte_alu byte_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op        (op),
    .opa       (opa),
    .opm       (opm),
    .carry_in  (carry_in),
    .out_valid (out_valid),
    .result    (result),
    .flag_n    (flag_n),
    .flag_v    (flag_v),
    .flag_z    (flag_z),
    .flag_c    (flag_c),
    .upd_n     (upd_n),
    .upd_v     (upd_v),
    .upd_z     (upd_z),
    .upd_c     (upd_c)
);

// File: tb/sim_byte_alu.sv
`timescale 1ns/1ps
module sim_byte_alu;

    localparam int WIDTH = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             in_valid = 1'b0;
    logic [3:0]       op = '0;
    logic [WIDTH-1:0] opa = '0;
    logic [WIDTH-1:0] opm = '0;
    logic             carry_in = 1'b0;
    logic             out_valid;
    logic [WIDTH-1:0] result;
    logic             flag_n, flag_v, flag_z, flag_c;
    logic             upd_n, upd_v, upd_z, upd_c;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    byte_alu #(.WIDTH(WIDTH)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op        (op),
        .opa       (opa),
        .opm       (opm),
        .carry_in  (carry_in),
        .out_valid (out_valid),
        .result    (result),
        .flag_n    (flag_n),
        .flag_v    (flag_v),
        .flag_z    (flag_z),
        .flag_c    (flag_c),
        .upd_n     (upd_n),
        .upd_v     (upd_v),
        .upd_z     (upd_z),
        .upd_c     (upd_c)
    );

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // drive one operation at a falling edge, sample one cycle later
    task automatic exec(input logic [3:0] o, input logic [7:0] a, input logic [7:0] m,
                        input logic ci);
        @(negedge clk);
        in_valid = 1'b1;
        op       = o;
        opa      = a;
        opm      = m;
        carry_in = ci;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // flags and enables are packed as {N,V,Z,C}
    task automatic expect_out(input string tag, input logic [7:0] r,
                              input logic [3:0] f, input logic [3:0] e);
        chk({tag, " result"}, result, r);
        chk({tag, " flags"}, {flag_n, flag_v, flag_z, flag_c}, f);
        chk({tag, " enables"}, {upd_n, upd_v, upd_z, upd_c}, e);
        chk({tag, " out_valid"}, out_valid, 1'b1);
    endtask

    task automatic t_reset();
        chk("R12 reset outputs",
            {out_valid, result, flag_n, flag_v, flag_z, flag_c, upd_n, upd_v, upd_z, upd_c},
            16'h0000);
    endtask

    task automatic t_add();
        exec(4'd0, 8'h50, 8'h50, 1'b0); expect_out("R2 R3 add 50+50", 8'hA0, 4'b1100, 4'b1111);
        exec(4'd0, 8'hFF, 8'h01, 1'b0); expect_out("R2 add wrap", 8'h00, 4'b0011, 4'b1111);
        exec(4'd0, 8'h01, 8'h01, 1'b1); expect_out("R2 add carry-in", 8'h03, 4'b0000, 4'b1111);
        exec(4'd0, 8'h80, 8'h80, 1'b0); expect_out("R3 add neg overflow", 8'h00, 4'b0111, 4'b1111);
    endtask

    task automatic t_add_sweep();
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 9; j++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    int a, m, s, sa, sm, ss;
                    a  = (i * 17) % 256;
                    m  = (j * 29 + 3) % 256;
                    s  = a + m + ci;
                    sa = (a > 127) ? a - 256 : a;
                    sm = (m > 127) ? m - 256 : m;
                    ss = sa + sm + ci;
                    exec(4'd0, a[7:0], m[7:0], ci[0]);
                    chk("R2 sweep sum", {flag_c, result}, s[8:0]);
                    chk("R3 sweep overflow", flag_v, (ss > 127 || ss < -128) ? 1'b1 : 1'b0);
                end
            end
        end
    endtask

    task automatic t_sub();
        exec(4'd1, 8'h50, 8'hF0, 1'b1); expect_out("R4 sub borrow", 8'h60, 4'b0000, 4'b1111);
        exec(4'd1, 8'h80, 8'h01, 1'b1); expect_out("R3 R4 sub overflow", 8'h7F, 4'b0101, 4'b1111);
        exec(4'd1, 8'h05, 8'h05, 1'b0); expect_out("R4 sub with borrow-in", 8'hFF, 4'b1000, 4'b1111);
        exec(4'd1, 8'h05, 8'h05, 1'b1); expect_out("R4 sub equal", 8'h00, 4'b0011, 4'b1111);
    endtask

    task automatic t_logic();
        exec(4'd2, 8'hF0, 8'h3C, 1'b1); expect_out("R5 and", 8'h30, 4'b0000, 4'b1010);
        exec(4'd3, 8'hAA, 8'hAA, 1'b1); expect_out("R5 xor zero", 8'h00, 4'b0010, 4'b1010);
        exec(4'd4, 8'h80, 8'h01, 1'b0); expect_out("R5 R13 or negative", 8'h81, 4'b1000, 4'b1010);
    endtask

    task automatic t_shift();
        exec(4'd5, 8'h81, 8'h00, 1'b0); expect_out("R6 shl", 8'h02, 4'b0001, 4'b1011);
        exec(4'd5, 8'h40, 8'h00, 1'b1); expect_out("R6 shl zero fill", 8'h80, 4'b1000, 4'b1011);
        exec(4'd6, 8'h01, 8'h00, 1'b0); expect_out("R6 shr", 8'h00, 4'b0011, 4'b1011);
        exec(4'd6, 8'h80, 8'h00, 1'b1); expect_out("R6 shr ignores carry", 8'h40, 4'b0000, 4'b1011);
    endtask

    task automatic t_rotate();
        exec(4'd7, 8'h80, 8'h00, 1'b1); expect_out("R7 rol", 8'h01, 4'b0001, 4'b1011);
        exec(4'd7, 8'h40, 8'h00, 1'b0); expect_out("R7 rol no carry", 8'h80, 4'b1000, 4'b1011);
        exec(4'd8, 8'h01, 8'h00, 1'b1); expect_out("R7 ror", 8'h80, 4'b1001, 4'b1011);
        exec(4'd8, 8'h02, 8'h00, 1'b0); expect_out("R7 ror no carry", 8'h01, 4'b0000, 4'b1011);
    endtask

    task automatic t_incdec();
        exec(4'd9,  8'hFF, 8'h55, 1'b1); expect_out("R8 inc wrap", 8'h00, 4'b0010, 4'b1010);
        exec(4'd9,  8'h7F, 8'h00, 1'b0); expect_out("R8 inc sign", 8'h80, 4'b1000, 4'b1010);
        exec(4'd10, 8'h00, 8'h00, 1'b1); expect_out("R8 dec wrap", 8'hFF, 4'b1000, 4'b1010);
    endtask

    task automatic t_cmp();
        exec(4'd11, 8'h10, 8'h10, 1'b0); expect_out("R9 cmp equal", 8'h00, 4'b0011, 4'b1011);
        exec(4'd11, 8'h10, 8'h20, 1'b1); expect_out("R9 cmp less", 8'hF0, 4'b1000, 4'b1011);
        exec(4'd11, 8'h20, 8'h10, 1'b0); expect_out("R9 cmp greater", 8'h10, 4'b0001, 4'b1011);
        exec(4'd11, 8'h00, 8'hFF, 1'b1); expect_out("R9 cmp extreme", 8'h01, 4'b0000, 4'b1011);
    endtask

    task automatic t_bit();
        exec(4'd12, 8'h0F, 8'hC0, 1'b1); expect_out("R10 bit zero top bits", 8'h00, 4'b1110, 4'b1110);
        exec(4'd12, 8'hFF, 8'h01, 1'b1); expect_out("R10 bit nonzero", 8'h01, 4'b0000, 4'b1110);
        exec(4'd12, 8'h00, 8'h40, 1'b0); expect_out("R10 bit v only", 8'h00, 4'b0110, 4'b1110);
    endtask

    task automatic t_unused();
        exec(4'd13, 8'h9C, 8'h12, 1'b1); expect_out("R11 code 13", 8'h9C, 4'b0000, 4'b0000);
        exec(4'd15, 8'h00, 8'hFF, 1'b1); expect_out("R11 code 15", 8'h00, 4'b0000, 4'b0000);
    endtask

    task automatic t_hold();
        exec(4'd0, 8'h12, 8'h34, 1'b0);
        expect_out("R1 latency", 8'h46, 4'b0000, 4'b1111);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R1 idle out_valid", out_valid, 1'b0);
            chk("R1 idle result held", result, 8'h46);
            chk("R1 idle enables held", {upd_n, upd_v, upd_z, upd_c}, 4'b1111);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_add();
        t_sub();
        t_logic();
        t_shift();
        t_rotate();
        t_incdec();
        t_cmp();
        t_bit();
        t_unused();
        t_hold();
        t_add_sweep();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule